// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block derives the serial clock timing of a two-wire bus master from a fast functional clock. A programmable prescaler first divides the functional clock into internal ticks. Each bus bit is then built from two timed phases: a low phase and a high phase. Each phase lasts a programmed count plus a fixed offset, measured in ticks. The resulting bit rate is fclk / ((P+1)·(L+7+H+5)). For example, a 48 MHz clock with P=1, L=5 and H=7 gives 1 MHz, and with P=1, L=111 and H=117 it gives 100 kHz.

The low and high timing registers are each 16 bits wide. The lower byte holds the count for standard and fast rates. The upper byte holds the count for the high-speed rate, and the `hs_mode` input chooses between the two. A neighbouring bit engine consumes the level request `scl_low_req` and three one-cycle strobes: the start of the low phase, the start of the high phase, and a sample point in the middle of the high phase.

Configuration is loaded through a simple synchronous write port. A new value is only picked up at a phase boundary, so a phase that is already running always completes with the timing it started with.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, with `en` low, `scl_low_req`, `low_start`, `high_start` and `mid_high` are all 0.
- R2: The low phase (`scl_low_req`=1) lasts (P+1)·(Lsel+7) clock cycles. Lsel is low-timing bits [7:0] when `hs_mode`=0.
- R3: The high phase (`scl_low_req`=0 while running) lasts (P+1)·(Hsel+5) clock cycles. Hsel is high-timing bits [7:0] when `hs_mode`=0.
- R4: P is the 8-bit prescaler value, and every tick spans P+1 clock cycles.
- R5: When `hs_mode`=1, Lsel and Hsel are taken from bits [15:8] of the low and high timing registers.
- R6: `low_start` pulses for one cycle in the first cycle of every low phase, and `high_start` pulses for one cycle in the first cycle of every high phase. At most one strobe is high in any cycle.
- R7: `mid_high` pulses for one cycle, (P+1)·floor((Hsel+5)/2) cycles after `high_start`.
- R8: Writes made while running leave the current phase unchanged. The prescaler, timing values and `hs_mode` are all sampled again at each phase boundary.
- R9: If `en` is sampled high while idle, the next cycle is the first cycle of a full low phase. If `en` is sampled low, the next cycle has `scl_low_req`=0 and no strobes, and all counters restart on the next enable.
- R10: The write port decodes `wr_sel` as follows: 0 writes the prescaler from `wr_data[7:0]`, 1 writes the low timing register, 2 writes the high timing register, and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low releases SCL and clears counters |
| hs_mode | input | 1 | Selects the upper timing bytes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 prescaler, 1 low, 2 high, 3 none) |
| wr_data | input | 16 | Write data |
| scl_low_req | output | 1 | Request to drive SCL low |
| low_start | output | 1 | First cycle of a low phase |
| high_start | output | 1 | First cycle of a high phase |
| mid_high | output | 1 | Sample point inside the high phase |

## Verification
The hardest condition to create is a configuration change that arrives partway through a phase. The old values must finish the current phase and the new ones must take over exactly at the boundary. The stimulus enables the block, waits three cycles, and rewrites the prescaler and both timing registers while the first low phase is still running. It then expects the first low phase at its old length, followed by a high phase and a low phase stretched by the new prescaler. A second corner case is disabling partway through a low phase and enabling again, which must produce a fresh full-length low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SEL_PSC  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int PSC_W = 8,
    localparam int HALF_W = REG_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              hs_mode,
    output logic [PSC_W-1:0]  cfg_psc,
    output logic [HALF_W-1:0] cfg_lo,
    output logic [HALF_W-1:0] cfg_hi
);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_PSC:  r_d.psc = wr_data[PSC_W-1:0];
                SEL_LOW:  r_d.lo  = wr_data;
                SEL_HIGH: r_d.hi  = wr_data;
                default:  r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_psc = r_q.psc;
    assign cfg_lo  = hs_mode ? r_q.lo[REG_W-1:HALF_W] : r_q.lo[HALF_W-1:0];
    assign cfg_hi  = hs_mode ? r_q.hi[REG_W-1:HALF_W] : r_q.hi[HALF_W-1:0];

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

    logic [PSC_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == psc);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int PSC_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5,
    localparam int TC_W    = HALF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [PSC_W-1:0]  cfg_psc,
    input  logic [HALF_W-1:0] cfg_lo,
    input  logic [HALF_W-1:0] cfg_hi,
    output logic              run,
    output logic [PSC_W-1:0]  psc_act,
    output logic              scl_low_req,
    output logic              low_start,
    output logic              high_start,
    output logic              mid_high
);

    localparam logic [TC_W-1:0] ONE = TC_W'(1);

    typedef struct packed {
        logic              run;
        phase_e            phase;
        logic [TC_W-1:0]   tcnt;
        logic [PSC_W-1:0]  psc_s;
        logic [HALF_W-1:0] lo_s;
        logic [HALF_W-1:0] hi_s;
        logic              ls;
        logic              hs;
        logic              mid;
    } seq_t;

    seq_t s_d, s_q;

    logic [TC_W-1:0] lo_len, hi_len, hi_half, cur_len, tcnt_inc;

    always_comb begin
        lo_len   = {1'b0, s_q.lo_s} + TC_W'(LOW_OFS);
        hi_len   = {1'b0, s_q.hi_s} + TC_W'(HIGH_OFS);
        hi_half  = hi_len >> 1;
        cur_len  = (s_q.phase == PH_LOW) ? lo_len : hi_len;
        tcnt_inc = s_q.tcnt + ONE;

        s_d     = s_q;
        s_d.ls  = 1'b0;
        s_d.hs  = 1'b0;
        s_d.mid = 1'b0;

        if (!en) begin
            s_d = '0;
        end else if (!s_q.run) begin
            s_d.run   = 1'b1;
            s_d.phase = PH_LOW;
            s_d.tcnt  = '0;
            s_d.psc_s = cfg_psc;
            s_d.lo_s  = cfg_lo;
            s_d.hi_s  = cfg_hi;
            s_d.ls    = 1'b1;
        end else if (tick) begin
            if (s_q.tcnt == cur_len - ONE) begin
                s_d.tcnt  = '0;
                s_d.psc_s = cfg_psc;
                s_d.lo_s  = cfg_lo;
                s_d.hi_s  = cfg_hi;
                if (s_q.phase == PH_LOW) begin
                    s_d.phase = PH_HIGH;
                    s_d.hs    = 1'b1;
                end else begin
                    s_d.phase = PH_LOW;
                    s_d.ls    = 1'b1;
                end
            end else begin
                s_d.tcnt = tcnt_inc;
                if (s_q.phase == PH_HIGH && tcnt_inc == hi_half)
                    s_d.mid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run         = s_q.run;
    assign psc_act     = s_q.psc_s;
    assign scl_low_req = s_q.run && (s_q.phase == PH_LOW);
    assign low_start   = s_q.ls;
    assign high_start  = s_q.hs;
    assign mid_high    = s_q.mid;

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int REG_W    = 16,
    parameter int PSC_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hs_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             scl_low_req,
    output logic             low_start,
    output logic             high_start,
    output logic             mid_high
);

    localparam int HALF_W = REG_W / 2;

    logic [PSC_W-1:0]  cfg_psc, psc_act;
    logic [HALF_W-1:0] cfg_lo, cfg_hi;
    logic              run, tick;

    scl_cfg_regs #(.REG_W(REG_W), .PSC_W(PSC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .hs_mode (hs_mode),
        .cfg_psc (cfg_psc),
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi)
    );

    scl_tick_div #(.PSC_W(PSC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psc   (psc_act),
        .tick  (tick)
    );

    scl_phase_seq #(
        .HALF_W   (HALF_W),
        .PSC_W    (PSC_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .tick        (tick),
        .cfg_psc     (cfg_psc),
        .cfg_lo      (cfg_lo),
        .cfg_hi      (cfg_hi),
        .run         (run),
        .psc_act     (psc_act),
        .scl_low_req (scl_low_req),
        .low_start   (low_start),
        .high_start  (high_start),
        .mid_high    (mid_high)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_low_req,
    input logic low_start,
    input logic high_start,
    input logic mid_high
);

    // R9
    release_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_low_req && !low_start && !high_start && !mid_high));

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start, mid_high}));

    // R6
    low_start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> scl_low_req);

    // R6
    high_start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> (!scl_low_req && $past(scl_low_req)));

    // R7
    mid_inside_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_high |-> (!scl_low_req && !$past(scl_low_req) && !$past(high_start)));

    // R6
    rise_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_req) |-> low_start);

    // R2
    fall_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_low_req) && $past(en)) |-> high_start);

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .scl_low_req (scl_low_req),
    .low_start   (low_start),
    .high_start  (high_start),
    .mid_high    (mid_high)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hs_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        scl_low_req, low_start, high_start, mid_high;

    always #4 clk = ~clk;

    scl_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .hs_mode(hs_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .scl_low_req(scl_low_req), .low_start(low_start),
        .high_start(high_start), .mid_high(mid_high)
    );

    // kind: 0 low_start, 1 high_start, 2 mid_high
    typedef struct { int kind; int gap; int req; } exp_t;
    exp_t q[$];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int last_ev = 0;
    bit done    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int req, input int act, input int exp_v, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (low_start || high_start || mid_high)) begin
            int kind;
            int lvl;
            kind = low_start ? 0 : (high_start ? 1 : 2);
            lvl  = (kind == 0) ? 1 : 0;
            chk((32'(low_start) + 32'(high_start) + 32'(mid_high)) == 1, 6,
                32'(low_start) + 32'(high_start) + 32'(mid_high), 1, "strobe count");
            if (q.size() == 0) begin
                chk(1'b0, 6, kind, -1, "unexpected strobe");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(kind == e.kind, e.req, kind, e.kind, "strobe kind");
                chk((cyc - last_ev) == e.gap, e.req, cyc - last_ev, e.gap, "strobe spacing");
                chk(32'(scl_low_req) == lvl, 6, 32'(scl_low_req), lvl, "level at strobe");
            end
            last_ev = cyc;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic push(input int kind, input int gap, input int req);
        exp_t e;
        e.kind = kind; e.gap = gap; e.req = req;
        q.push_back(e);
    endtask

    task automatic start_run();
        last_ev = cyc;
        en = 1'b1;
    endtask

    task automatic drain_and_stop(input int req);
        while (q.size() != 0) step();
        en = 1'b0;
        step();
        @(negedge clk);
        chk(!scl_low_req && !low_start && !high_start && !mid_high, req,
            32'(scl_low_req), 0, "released after disable (R9)");
        step();
    endtask

    // run a config for nb bits; tag overrides requirement labels when non-zero
    task automatic run_case(input int p, input int lo, input int hi, input bit hs, input int nb, input int tag);
        int lsel, hsel, L, H, half;
        lsel = hs ? (lo >> 8) & 255 : lo & 255;
        hsel = hs ? (hi >> 8) & 255 : hi & 255;
        L = lsel + 7; H = hsel + 5; half = H / 2;
        wr(2'd0, 16'(p));
        wr(2'd1, 16'(lo));
        wr(2'd2, 16'(hi));
        hs_mode = hs;
        push(0, 1, tag != 0 ? tag : 9);
        for (int b = 0; b < nb; b++) begin
            push(1, (p + 1) * L, tag != 0 ? tag : 2);
            push(2, (p + 1) * half, tag != 0 ? tag : 7);
            push(0, (p + 1) * (H - half), tag != 0 ? tag : 3);
        end
        start_run();
        drain_and_stop(9);
        hs_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!scl_low_req, 1, 32'(scl_low_req), 0, "scl_low_req after reset");
        chk(!low_start && !high_start && !mid_high, 1,
            32'(low_start) + 32'(high_start) + 32'(mid_high), 0, "strobes after reset");
        step();

        // R2 R3 R7: fast-rate style setting
        run_case(1, 5, 7, 1'b0, 2, 0);
        // shortest phases
        run_case(0, 0, 0, 1'b0, 2, 0);
        // R4: larger prescaler
        run_case(3, 2, 4, 1'b0, 2, 4);
        // R5: upper bytes in high-speed mode
        run_case(0, 16'h0305, 16'h0107, 1'b1, 2, 5);

        // R10: select 3 must not alter any register
        wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd2);
        wr(2'd3, 16'hFFFF);
        push(0, 1, 10); push(1, 8, 10); push(2, 3, 10); push(0, 4, 10);
        start_run();
        drain_and_stop(10);

        // R8: rewrite everything during the first low phase
        wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd2);
        push(0, 1, 8);
        push(1, 8, 8);   // old low length 1*(1+7)
        push(2, 8, 8);   // new: 2*floor(9/2)
        push(0, 10, 8);  // 2*9 - 8
        push(1, 32, 8);  // 2*(9+7)
        push(2, 8, 8);
        push(0, 10, 8);
        start_run();
        repeat (3) step();
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd4);
        drain_and_stop(8);

        // R9: disable partway through a low phase, then restart cleanly
        wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd2);
        push(0, 1, 9);
        start_run();
        while (q.size() != 0) step();
        repeat (2) step();
        en = 1'b0;
        step();
        @(negedge clk);
        chk(!scl_low_req, 9, 32'(scl_low_req), 0, "released mid-phase");
        step();
        push(0, 1, 9); push(1, 8, 9); push(2, 3, 9); push(0, 4, 9);
        start_run();
        drain_and_stop(9);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule